// File: doc/BRIEF.md
# Keyboard and Display Port Controller

This block gives a processor two character channels as byte-wide registers on a plain load/store bus. The input channel receives characters from a keyboard model over a one-cycle valid strobe. It keeps the newest character and raises a ready flag that software can poll. The output channel takes a character stored by software and offers it to a display model over a valid/ready handshake. When the display accepts the character, the channel raises its own ready flag.

Each channel has a control register that holds an interrupt enable. A channel requests an interrupt while its flag and its enable are both set. The ready flags clear when software reads the channel's status register, or when the processor acknowledges that channel's interrupt. Reading a data register never clears a flag.

The input channel runs a three-state machine: EMPTY, FULL and OVERRUN. A character arriving in EMPTY moves it to FULL. A character arriving in FULL or OVERRUN moves it to OVERRUN. A status read or an acknowledge with no character arriving moves it to EMPTY. A character that arrives on the same edge as a status read or acknowledge moves it to FULL.

The output channel runs a two-state machine: IDLE and SEND. A store in IDLE moves it to SEND. In SEND, the handshake completing with no new store moves it to IDLE. A store in SEND keeps it in SEND with the new character.

Top module: `kdi_top`

## Requirements
- R1: The register offsets are: input data 0, input status 1, input control 2, output data 4, output status 5, output control 6. A read drives `rdata` on the clock edge that samples `rd_en`, so the value is visible the cycle after the request. Reads of unmapped offsets return 0. The output data register reads back the last stored character.
- R2: After reset, the input ready flag and the overrun bit are 0 (input status reads 0x00), the output ready flag is 1 (output status reads 0x04), both interrupt enables are 0, `dp_valid` is 0 and both interrupt requests are 0.
- R3: A character arriving with `kb_valid` is placed in the input data register and sets the input ready flag at bit 1 of the input status register.
- R4: A read of the input status register returns the current flags and then clears the ready flag and the overrun bit. A read of the input data register leaves both unchanged. If a character arrives on the same edge as a status read, the ready flag stays set and the overrun bit clears.
- R5: A character arriving while the input ready flag is set overwrites the data register and sets the sticky overrun bit at bit 0 of the input status register.
- R6: A store to the output data register drives the character on `dp_char` with `dp_valid` high the next cycle. It also clears the output ready flag. `dp_valid` and `dp_char` hold until `dp_ready` is seen high.
- R7: When the handshake completes (`dp_valid` and `dp_ready` both high on an edge with no store), the output ready flag at bit 2 of the output status register is set. A read of the output status register clears it, unless a completion occurs on the same edge.
- R8: A store to the output data register while a character is still pending replaces the pending character and keeps `dp_valid` high. No error indication of any kind is raised.
- R9: Bit 0 of each control register is that channel's interrupt enable. Its interrupt output (`kb_irq` or `dp_irq`) is high exactly when its ready flag and its enable are both 1.
- R10: An acknowledge on `irq_ack[0]` (input channel) or `irq_ack[1]` (output channel) clears that channel's ready flag, and its interrupt request drops the next cycle. For the input channel, this applies only when no character arrives on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Store strobe |
| rd_en | input | 1 | Load strobe |
| wdata | input | DATA_W | Store data |
| rdata | output | DATA_W | Load data, registered |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_char | input | DATA_W | Keyboard character |
| dp_valid | output | 1 | Character offered to the display |
| dp_char | output | DATA_W | Character for the display |
| dp_ready | input | 1 | Display accepts the offered character |
| irq_ack | input | 2 | Interrupt acknowledge, bit 0 input channel, bit 1 output channel |
| kb_irq | output | 1 | Input channel interrupt request |
| dp_irq | output | 1 | Output channel interrupt request |

## Verification
The properties assume several things about the inputs. Stores and loads are never issued on the same cycle. `kb_valid` is a single-cycle strobe. `dp_ready` only matters while `dp_valid` is high. The stimulus follows these rules. Every bus access is a one-cycle pulse driven away from the clock edge, with at most one of `wr_en` or `rd_en` high. The display model raises `dp_ready` for exactly one cycle, and only after `dp_valid` has been seen high. The same-edge cases (a character arriving during a status read, a store while a character is pending) are driven on purpose, because the state machines give them a defined priority.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
    typedef enum logic [1:0] {
        K_EMPTY    = 2'd0,
        K_FULL     = 2'd1,
        K_OVERRUN  = 2'd2
    } kb_state_t;

    typedef enum logic {
        D_IDLE = 1'b0,
        D_SEND = 1'b1
    } dp_state_t;

    localparam int OFF_KB_DATA = 0;
    localparam int OFF_KB_STAT = 1;
    localparam int OFF_KB_CTRL = 2;
    localparam int OFF_DP_DATA = 4;
    localparam int OFF_DP_STAT = 5;
    localparam int OFF_DP_CTRL = 6;

    localparam int KB_RDY_BIT = 1;
    localparam int KB_OVR_BIT = 0;
    localparam int DP_RDY_BIT = 2;
    localparam int IE_BIT     = 0;

    localparam int NUM_CH = 2;
    localparam int CH_KB  = 0;
    localparam int CH_DP  = 1;
endpackage

// File: rtl/kdi_kbd_chan.sv
module kdi_kbd_chan
    import kdi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_char,
    input  logic              stat_rd,
    input  logic              ack,
    output logic [DATA_W-1:0] data_q,
    output logic              ready,
    output logic              overrun
);
    kb_state_t state_q, state_d;
    logic      clear;

    assign clear = stat_rd | ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= K_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            K_EMPTY: begin
                if (key_valid) state_d = K_FULL;
            end
            K_FULL, K_OVERRUN: begin
                if (key_valid && clear)  state_d = K_FULL;
                else if (key_valid)      state_d = K_OVERRUN;
                else if (clear)          state_d = K_EMPTY;
            end
            default: state_d = K_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (key_valid) begin
            data_q <= key_char;
        end
    end

    always_comb begin
        ready   = 1'b0;
        overrun = 1'b0;
        unique case (state_q)
            K_EMPTY:   ;
            K_FULL:    ready = 1'b1;
            K_OVERRUN: begin
                ready   = 1'b1;
                overrun = 1'b1;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/kdi_disp_chan.sv
module kdi_disp_chan
    import kdi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_rd,
    input  logic              ack,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_char,
    output logic              ready_flag
);
    dp_state_t state_q, state_d;
    logic      done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= D_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            D_IDLE: begin
                if (store) state_d = D_SEND;
            end
            D_SEND: begin
                if (!store && out_ready) begin
                    state_d = D_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = D_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == D_SEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_char <= '0;
        end else if (store) begin
            out_char <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_flag <= 1'b1;
        end else if (store) begin
            ready_flag <= 1'b0;
        end else if (done) begin
            ready_flag <= 1'b1;
        end else if (stat_rd || ack) begin
            ready_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/kdi_bus_decode.sv
module kdi_bus_decode
    import kdi_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] kb_data,
    input  logic              kb_ready,
    input  logic              kb_overrun,
    input  logic              kb_ie,
    input  logic [DATA_W-1:0] dp_data,
    input  logic              dp_ready_flag,
    input  logic              dp_ie,
    output logic              kb_stat_rd,
    output logic              kb_ctrl_wr,
    output logic              dp_store,
    output logic              dp_stat_rd,
    output logic              dp_ctrl_wr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_KB_DATA = ADDR_W'(OFF_KB_DATA);
    localparam logic [ADDR_W-1:0] A_KB_STAT = ADDR_W'(OFF_KB_STAT);
    localparam logic [ADDR_W-1:0] A_KB_CTRL = ADDR_W'(OFF_KB_CTRL);
    localparam logic [ADDR_W-1:0] A_DP_DATA = ADDR_W'(OFF_DP_DATA);
    localparam logic [ADDR_W-1:0] A_DP_STAT = ADDR_W'(OFF_DP_STAT);
    localparam logic [ADDR_W-1:0] A_DP_CTRL = ADDR_W'(OFF_DP_CTRL);

    logic [DATA_W-1:0] rd_mux;

    assign kb_stat_rd = rd_en && (addr == A_KB_STAT);
    assign dp_stat_rd = rd_en && (addr == A_DP_STAT);
    assign kb_ctrl_wr = wr_en && (addr == A_KB_CTRL);
    assign dp_ctrl_wr = wr_en && (addr == A_DP_CTRL);
    assign dp_store   = wr_en && (addr == A_DP_DATA);

    always_comb begin
        rd_mux = '0;
        if (addr == A_KB_DATA) begin
            rd_mux = kb_data;
        end else if (addr == A_KB_STAT) begin
            rd_mux[KB_RDY_BIT] = kb_ready;
            rd_mux[KB_OVR_BIT] = kb_overrun;
        end else if (addr == A_KB_CTRL) begin
            rd_mux[IE_BIT] = kb_ie;
        end else if (addr == A_DP_DATA) begin
            rd_mux = dp_data;
        end else if (addr == A_DP_STAT) begin
            rd_mux[DP_RDY_BIT] = dp_ready_flag;
        end else if (addr == A_DP_CTRL) begin
            rd_mux[IE_BIT] = dp_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/kdi_top.sv
module kdi_top
    import kdi_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_char,
    output logic              dp_valid,
    output logic [DATA_W-1:0] dp_char,
    input  logic              dp_ready,
    input  logic [1:0]        irq_ack,
    output logic              kb_irq,
    output logic              dp_irq
);
    logic [DATA_W-1:0] kb_data;
    logic              kb_ready, kb_overrun, kb_stat_rd, kb_ctrl_wr;
    logic              dp_ready_flag, dp_store, dp_stat_rd, dp_ctrl_wr;
    logic              kb_ie, dp_ie;

    kdi_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .kb_data       (kb_data),
        .kb_ready      (kb_ready),
        .kb_overrun    (kb_overrun),
        .kb_ie         (kb_ie),
        .dp_data       (dp_char),
        .dp_ready_flag (dp_ready_flag),
        .dp_ie         (dp_ie),
        .kb_stat_rd    (kb_stat_rd),
        .kb_ctrl_wr    (kb_ctrl_wr),
        .dp_store      (dp_store),
        .dp_stat_rd    (dp_stat_rd),
        .dp_ctrl_wr    (dp_ctrl_wr),
        .rdata         (rdata)
    );

    kdi_kbd_chan #(.DATA_W(DATA_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (kb_valid),
        .key_char  (kb_char),
        .stat_rd   (kb_stat_rd),
        .ack       (irq_ack[CH_KB]),
        .data_q    (kb_data),
        .ready     (kb_ready),
        .overrun   (kb_overrun)
    );

    kdi_disp_chan #(.DATA_W(DATA_W)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (dp_store),
        .wdata      (wdata),
        .stat_rd    (dp_stat_rd),
        .ack        (irq_ack[CH_DP]),
        .out_ready  (dp_ready),
        .out_valid  (dp_valid),
        .out_char   (dp_char),
        .ready_flag (dp_ready_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kb_ie <= 1'b0;
            dp_ie <= 1'b0;
        end else begin
            if (kb_ctrl_wr) kb_ie <= wdata[IE_BIT];
            if (dp_ctrl_wr) dp_ie <= wdata[IE_BIT];
        end
    end

    assign kb_irq = kb_ie & kb_ready;
    assign dp_irq = dp_ie & dp_ready_flag;
endmodule

// File: rtl/kdi_checker.sv
module kdi_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              kb_valid,
    input logic              dp_valid,
    input logic [DATA_W-1:0] dp_char,
    input logic              dp_ready,
    input logic [1:0]        irq_ack,
    input logic              kb_irq,
    input logic              dp_irq,
    input logic              kb_ie,
    input logic              dp_ready_flag
);
    logic store, kb_srd, kb_cwr;
    assign store  = wr_en && (addr == ADDR_W'(4));
    assign kb_srd = rd_en && (addr == ADDR_W'(1));
    assign kb_cwr = wr_en && (addr == ADDR_W'(2));

    AST_KB_ARRIVAL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid && kb_ie && !kb_cwr |=> kb_irq); // R3

    AST_KB_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        kb_srd && !kb_valid |=> !kb_irq); // R4

    AST_DP_STORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> dp_valid && !dp_ready_flag); // R6

    AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && !dp_ready && !store |=> dp_valid && $stable(dp_char)); // R6

    AST_DP_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && dp_ready && !store |=> dp_ready_flag && !dp_valid); // R7

    AST_DP_BUSY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dp_valid && store |=> dp_valid); // R8

    AST_KB_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack[0] && !kb_valid |=> !kb_irq); // R10

    AST_DP_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack[1] && !(dp_valid && dp_ready) |=> !dp_irq); // R10
endmodule

bind kdi_top kdi_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .kb_valid      (kb_valid),
    .dp_valid      (dp_valid),
    .dp_char       (dp_char),
    .dp_ready      (dp_ready),
    .irq_ack       (irq_ack),
    .kb_irq        (kb_irq),
    .dp_irq        (dp_irq),
    .kb_ie         (kb_ie),
    .dp_ready_flag (dp_ready_flag)
);

// File: tb/test_kdi_top.sv
module test_kdi_top;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0, rdata;
    logic              kb_valid = 1'b0;
    logic [DATA_W-1:0] kb_char = '0;
    logic              dp_valid;
    logic [DATA_W-1:0] dp_char;
    logic              dp_ready = 1'b0;
    logic [1:0]        irq_ack = '0;
    logic              kb_irq, dp_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [DATA_W-1:0] exp_q[$];
    string             tag_q[$];
    logic              rd_seen = 1'b0;

    always #5 clk = ~clk;

    kdi_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_kdi_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .kb_valid(kb_valid), .kb_char(kb_char),
        .dp_valid(dp_valid), .dp_char(dp_char), .dp_ready(dp_ready),
        .irq_ack(irq_ack), .kb_irq(kb_irq), .dp_irq(dp_irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected read", rdata, 'x);
            end else begin
                automatic logic [DATA_W-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    task automatic bus_read(input int a, input logic [DATA_W-1:0] exp, input string tag);
        @(negedge clk);
        addr = ADDR_W'(a); rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_write(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic key(input logic [DATA_W-1:0] c);
        @(negedge clk);
        kb_valid = 1'b1; kb_char = c;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk);
        dp_ready = 1'b1;
        @(negedge clk);
        dp_ready = 1'b0;
    endtask

    task automatic ack(input int ch);
        @(negedge clk);
        irq_ack[ch] = 1'b1;
        @(negedge clk);
        irq_ack = '0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 kb_irq", kb_irq, 0);
        check("R2 dp_irq", dp_irq, 0);
        check("R2 dp_valid", dp_valid, 0);
        bus_read(1, 8'h00, "R2 kb status");
        bus_read(5, 8'h04, "R2 dp status");
        bus_read(2, 8'h00, "R2 kb ctrl");
        bus_read(6, 8'h00, "R2 dp ctrl");
        bus_read(3, 8'h00, "R1 unmapped");

        // R3 arrival, R4 data read keeps flag
        key(8'h41);
        bus_read(0, 8'h41, "R3 kb data");
        bus_read(1, 8'h02, "R4 status after data read");
        bus_read(1, 8'h00, "R4 status cleared");
        bus_read(0, 8'h41, "R1 data persists");

        // R5 overrun
        key(8'h10);
        key(8'h20);
        bus_read(0, 8'h20, "R5 newest char");
        bus_read(1, 8'h03, "R5 overrun set");
        bus_read(1, 8'h00, "R5 overrun cleared");

        // R4 arrival on same edge as status read
        key(8'h30);
        key(8'h31);
        @(negedge clk);
        addr = 3'd1; rd_en = 1'b1; kb_valid = 1'b1; kb_char = 8'h32;
        exp_q.push_back(8'h03); tag_q.push_back("R4 same-edge read value");
        @(negedge clk);
        rd_en = 1'b0; kb_valid = 1'b0;
        bus_read(1, 8'h02, "R4 flag kept, overrun gone");
        bus_read(0, 8'h32, "R4 same-edge char");

        // R9 / R10 keyboard interrupt
        bus_write(2, 8'h01);
        check("R9 kb irq off with no flag", kb_irq, 0);
        key(8'h55);
        check("R9 kb irq on", kb_irq, 1);
        ack(0);
        check("R10 kb irq dropped", kb_irq, 0);
        bus_read(1, 8'h00, "R10 kb flag cleared by ack");
        bus_read(2, 8'h01, "R9 kb ctrl readback");

        // R6 / R7 display transfer
        bus_write(4, 8'h61);
        check("R6 dp_valid", dp_valid, 1);
        check("R6 dp_char", dp_char, 8'h61);
        bus_read(5, 8'h00, "R6 dp flag cleared by store");
        repeat (3) @(negedge clk);
        check("R6 dp_valid held", dp_valid, 1);
        check("R6 dp_char held", dp_char, 8'h61);
        accept();
        check("R7 dp_valid drop", dp_valid, 0);
        bus_read(5, 8'h04, "R7 dp flag set");
        bus_read(5, 8'h00, "R7 dp flag cleared");
        bus_read(4, 8'h61, "R1 dp data readback");

        // R8 store while busy
        bus_write(4, 8'h62);
        bus_write(4, 8'h63);
        check("R8 dp_char replaced", dp_char, 8'h63);
        check("R8 dp_valid kept", dp_valid, 1);
        bus_read(5, 8'h00, "R8 no flag while pending");
        accept();
        check("R8 dp done", dp_valid, 0);

        // R9 / R10 display interrupt
        check("R9 dp irq off while disabled", dp_irq, 0);
        bus_write(6, 8'h01);
        check("R9 dp irq on", dp_irq, 1);
        ack(1);
        check("R10 dp irq dropped", dp_irq, 0);
        bus_read(5, 8'h00, "R10 dp flag cleared by ack");

        @(negedge clk);
        @(negedge clk);
        summary();
    end
endmodule